// File: doc/BRIEF.md
# Clock-Stop Output Gating

This block sits in front of the output pads of a clock generator and decides, cycle by cycle, which derived clocks may reach the board. It receives a free-running fixed clock, five stoppable clocks that run in phase with it, and one memory clock that fans out to a bank of copies. An active-low stop request silences the five stoppable clocks, and a separate active-low stop silences the memory bank. A global enable pin takes all three groups off the pads.

All logic runs on a core sampling clock `clk` that is much faster than the gated clocks. Each clock waveform arrives as a level on a data input and leaves as a registered level, one `clk` cycle later. The stop request passes through a two-flop synchronizer. It is then captured on a rising edge of the fixed clock and applied on the next rising edge. The gate itself may change only while the fixed clock is low, so no output pulse is ever shortened. A mode bit is sampled while reset is held. When that bit is 0 the stop function is absent and the stoppable clocks always run.

Top module: `clkstop_gate`

## Requirements
- R1: While `rst` is high, every clock output and every drive enable is 0.
- R2: `fix_clk_o` equals `fix_clk_i` delayed by one `clk` cycle, whatever the stop, mode and memory-stop inputs are.
- R3: With the latched mode bit at 1, once the stop request has settled, `pci_stop_n_i` low holds all bits of `pci_clk_o` at 0, and `pci_stop_n_i` high lets each bit follow its source one cycle late.
- R4: Suppose `pci_stop_n_i` changes at least two `clk` cycles before a rising edge of the fixed clock. Then the high pulses that start at that rising edge and at the next one still show the old stop state. The new state applies from the third rising edge onward.
- R5: The gate of the stoppable clocks changes only while the fixed clock is low. Every high pulse on `pci_clk_o` therefore lasts exactly as long as the fixed clock's high phase, and it rises and falls together with `fix_clk_o`.
- R6: `mode_i` is sampled only while `rst` is high. When the sampled value is 0, `pci_stop_n_i` has no effect. A change of `mode_i` after reset has no effect until the next reset.
- R7: Once it has settled, `mem_stop_n_i` low holds all bits of `mem_clk_o` at 0. When it is high, every bit of `mem_clk_o` follows `mem_clk_i` one cycle late.
- R8: The memory gate changes only while `mem_clk_i` is low.
- R9: `fix_oe_o`, `pci_oe_o` and `mem_oe_o` each equal `oe_i` delayed by one `clk` cycle. A 0 means the group's pads are high impedance, and this does not depend on any stop input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst | input | 1 | Synchronous active-high reset; `mode_i` is latched while it is high |
| mode_i | input | 1 | 1 enables the stop function |
| oe_i | input | 1 | Global output enable; 0 puts all groups in high impedance |
| fix_clk_i | input | 1 | Free-running fixed clock level |
| pci_src_i | input | PCI_W (5) | Stoppable clock sources, in phase with `fix_clk_i` |
| pci_stop_n_i | input | 1 | Active-low stop request for the stoppable clocks, asynchronous |
| mem_clk_i | input | 1 | Memory clock level that feeds the bank |
| mem_stop_n_i | input | 1 | Active-low stop for the memory bank, asynchronous |
| fix_clk_o | output | 1 | Fixed clock output, never stopped |
| pci_clk_o | output | PCI_W (5) | Gated stoppable clocks |
| mem_clk_o | output | MEM_W (13) | Gated memory clock copies |
| fix_oe_o | output | 1 | Drive enable of the fixed clock pad |
| pci_oe_o | output | 1 | Drive enable of the stoppable clock pads |
| mem_oe_o | output | 1 | Drive enable of the memory bank pads |

## Verification
The edge-alignment properties assume two things about the inputs. First, every stoppable source rises and falls in the same `clk` cycle as the fixed clock. Second, each clock level stays high or low for at least two `clk` cycles. Without these assumptions, a pulse on `pci_clk_o` could start or end without a matching edge on `fix_clk_o`. The stimulus therefore derives all five sources and the fixed clock from one phase counter, with eight `clk` cycles per period. The memory clock comes from a second counter with six `clk` cycles per period. Inputs change only on falling edges of `clk`, and `mode_i` is set before each reset.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    localparam int unsigned PCI_W_DEF = 5;
    localparam int unsigned MEM_W_DEF = 13;
    localparam int unsigned SYNC_DEF  = 2;

    // Drive enables of the three pad groups.
    typedef struct packed {
        logic fix;
        logic pci;
        logic mem;
    } drive_en_t;

    // Replicate a single gated level onto a bus of any width.
    function automatic logic [63:0] fan_out(input logic lvl);
        return {64{lvl}};
    endfunction

    // Stop function present only when the latched mode selects it.
    function automatic logic run_request(input logic mode_sel, input logic applied_run);
        return mode_sel ? applied_run : 1'b1;
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int unsigned STAGES = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {N{RST_VAL}};
        else     chain_q <= {chain_q[N-2:0], d_i};
    end

    assign q_o = chain_q[N-1];
endmodule

// File: rtl/clkstop_pci_ctrl.sv
module clkstop_pci_ctrl
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_i,
    input  logic fix_clk_i,
    input  logic stop_n_sync_i,
    output logic mode_o,
    output logic run_req_o
);
    logic mode_q;
    logic fix_prev_q;
    logic cap_q;
    logic app_q;
    logic fix_rise;

    assign fix_rise = fix_clk_i & ~fix_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= mode_i;
            fix_prev_q <= 1'b0;
            cap_q      <= 1'b1;
            app_q      <= 1'b1;
        end else begin
            fix_prev_q <= fix_clk_i;
            if (fix_rise) begin
                cap_q <= stop_n_sync_i;   // sampled at this rising edge
                app_q <= cap_q;           // acts from the following rising edge
            end
        end
    end

    assign mode_o    = mode_q;
    assign run_req_o = run_request(mode_q, app_q);
endmodule

// File: rtl/clkstop_lowgate.sv
module clkstop_lowgate (
    input  logic clk,
    input  logic rst,
    input  logic ref_i,
    input  logic req_i,
    output logic run_o
);
    logic run_q;

    // The gate follows its request only while the reference clock is low.
    always_ff @(posedge clk) begin
        if (rst)        run_q <= 1'b1;
        else if (!ref_i) run_q <= req_i;
    end

    assign run_o = run_q;
endmodule

// File: rtl/clkstop_drive.sv
module clkstop_drive
    import clkstop_pkg::*;
#(
    parameter int unsigned PCI_W = PCI_W_DEF,
    parameter int unsigned MEM_W = MEM_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oe_i,
    input  logic             fix_clk_i,
    input  logic [PCI_W-1:0] pci_src_i,
    input  logic             pci_run_i,
    input  logic             mem_clk_i,
    input  logic             mem_run_i,
    output logic             fix_clk_o,
    output logic [PCI_W-1:0] pci_clk_o,
    output logic [MEM_W-1:0] mem_clk_o,
    output drive_en_t        en_o
);
    logic [PCI_W-1:0] pci_mask;
    logic             mem_lvl;

    assign pci_mask = fan_out(pci_run_i)[PCI_W-1:0];
    assign mem_lvl  = mem_clk_i & mem_run_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            fix_clk_o <= 1'b0;
            pci_clk_o <= '0;
            en_o      <= '0;
        end else begin
            fix_clk_o <= fix_clk_i;
            pci_clk_o <= pci_src_i & pci_mask;
            en_o      <= '{fix: oe_i, pci: oe_i, mem: oe_i};
        end
    end

    for (genvar gi = 0; gi < MEM_W; gi++) begin : g_mem_copy
        always_ff @(posedge clk) begin
            if (rst) mem_clk_o[gi] <= 1'b0;
            else     mem_clk_o[gi] <= mem_lvl;
        end
    end
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int unsigned PCI_W       = PCI_W_DEF,
    parameter int unsigned MEM_W       = MEM_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_i,
    input  logic             oe_i,
    input  logic             fix_clk_i,
    input  logic [PCI_W-1:0] pci_src_i,
    input  logic             pci_stop_n_i,
    input  logic             mem_clk_i,
    input  logic             mem_stop_n_i,
    output logic             fix_clk_o,
    output logic [PCI_W-1:0] pci_clk_o,
    output logic [MEM_W-1:0] mem_clk_o,
    output logic             fix_oe_o,
    output logic             pci_oe_o,
    output logic             mem_oe_o
);
    logic      pci_stop_n_s;
    logic      mem_stop_n_s;
    logic      mode_q;
    logic      pci_req;
    logic      pci_run;
    logic      mem_run;
    drive_en_t en;

    clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pci_sync (
        .clk(clk), .rst(rst), .d_i(pci_stop_n_i), .q_o(pci_stop_n_s));

    clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mem_sync (
        .clk(clk), .rst(rst), .d_i(mem_stop_n_i), .q_o(mem_stop_n_s));

    clkstop_pci_ctrl u_pci_ctrl (
        .clk(clk), .rst(rst), .mode_i(mode_i), .fix_clk_i(fix_clk_i),
        .stop_n_sync_i(pci_stop_n_s), .mode_o(mode_q), .run_req_o(pci_req));

    clkstop_lowgate u_pci_gate (
        .clk(clk), .rst(rst), .ref_i(fix_clk_i), .req_i(pci_req), .run_o(pci_run));

    clkstop_lowgate u_mem_gate (
        .clk(clk), .rst(rst), .ref_i(mem_clk_i), .req_i(mem_stop_n_s), .run_o(mem_run));

    clkstop_drive #(.PCI_W(PCI_W), .MEM_W(MEM_W)) u_drive (
        .clk(clk), .rst(rst), .oe_i(oe_i),
        .fix_clk_i(fix_clk_i), .pci_src_i(pci_src_i), .pci_run_i(pci_run),
        .mem_clk_i(mem_clk_i), .mem_run_i(mem_run),
        .fix_clk_o(fix_clk_o), .pci_clk_o(pci_clk_o), .mem_clk_o(mem_clk_o),
        .en_o(en));

    assign fix_oe_o = en.fix;
    assign pci_oe_o = en.pci;
    assign mem_oe_o = en.mem;
endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk #(
    parameter int unsigned PCI_W = 5,
    parameter int unsigned MEM_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             oe_i,
    input logic             fix_clk_i,
    input logic             mem_clk_i,
    input logic             fix_clk_o,
    input logic [PCI_W-1:0] pci_clk_o,
    input logic [MEM_W-1:0] mem_clk_o,
    input logic             fix_oe_o,
    input logic             pci_oe_o,
    input logic             mem_oe_o,
    input logic             pci_run,
    input logic             mem_run,
    input logic             mode_q
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (fix_clk_o == 1'b0 && pci_clk_o == '0 && mem_clk_o == '0 &&
                        !fix_oe_o && !pci_oe_o && !mem_oe_o));

    a_r2_fix_follows: assert property (@(posedge clk) disable iff (!armed)
        fix_clk_o == $past(fix_clk_i));

    a_r3_stopped_low: assert property (@(posedge clk) disable iff (!armed)
        !pci_run |=> (pci_clk_o == '0));

    a_r5_gate_when_low: assert property (@(posedge clk) disable iff (!armed)
        !$stable(pci_run) |-> !$past(fix_clk_i));

    a_r5_no_runt_fall: assert property (@(posedge clk) disable iff (!armed)
        $fell(pci_clk_o[0]) |-> $fell(fix_clk_o));

    a_r5_no_runt_rise: assert property (@(posedge clk) disable iff (!armed)
        $rose(pci_clk_o[0]) |-> $rose(fix_clk_o));

    a_r6_mode_held: assert property (@(posedge clk) disable iff (!armed)
        $stable(mode_q));

    a_r7_mem_stopped_low: assert property (@(posedge clk) disable iff (!armed)
        !mem_run |=> (mem_clk_o == '0));

    a_r8_mem_gate_when_low: assert property (@(posedge clk) disable iff (!armed)
        !$stable(mem_run) |-> !$past(mem_clk_i));

    a_r9_enables: assert property (@(posedge clk) disable iff (!armed)
        (fix_oe_o == $past(oe_i)) && (pci_oe_o == $past(oe_i)) && (mem_oe_o == $past(oe_i)));
endmodule

bind clkstop_gate clkstop_gate_chk #(.PCI_W(PCI_W), .MEM_W(MEM_W)) u_chk (
    .clk(clk), .rst(rst), .oe_i(oe_i), .fix_clk_i(fix_clk_i), .mem_clk_i(mem_clk_i),
    .fix_clk_o(fix_clk_o), .pci_clk_o(pci_clk_o), .mem_clk_o(mem_clk_o),
    .fix_oe_o(fix_oe_o), .pci_oe_o(pci_oe_o), .mem_oe_o(mem_oe_o),
    .pci_run(pci_run), .mem_run(mem_run), .mode_q(mode_q));

// File: tb/clkstop_gate_bench.sv
module clkstop_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PCI_W = 5;
    localparam int MEM_W = 13;
    localparam int FIX_LEN = 8;   // core cycles per fixed-clock period, 4 high
    localparam int MEM_LEN = 6;   // core cycles per memory-clock period, 3 high

    // {mode, stop_n, mem_stop_n, oe, exp_pci_run, exp_mem_run}
    localparam logic [5:0] VEC [8] = '{
        6'b1111_11, 6'b1011_01, 6'b1001_00, 6'b1100_10,
        6'b0011_11, 6'b0000_10, 6'b0110_11, 6'b1110_11 };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_i = 1'b1, oe_i = 1'b0, fix_clk_i = 1'b0, mem_clk_i = 1'b0;
    logic pci_stop_n_i = 1'b1, mem_stop_n_i = 1'b1;
    logic [PCI_W-1:0] pci_src_i = '0;
    logic fix_clk_o, fix_oe_o, pci_oe_o, mem_oe_o;
    logic [PCI_W-1:0] pci_clk_o;
    logic [MEM_W-1:0] mem_clk_o;

    int ph = FIX_LEN - 1;
    int mph = MEM_LEN - 1;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    clkstop_gate #(.PCI_W(PCI_W), .MEM_W(MEM_W)) u_clkstop_gate (
        .clk(clk), .rst(rst), .mode_i(mode_i), .oe_i(oe_i), .fix_clk_i(fix_clk_i),
        .pci_src_i(pci_src_i), .pci_stop_n_i(pci_stop_n_i), .mem_clk_i(mem_clk_i),
        .mem_stop_n_i(mem_stop_n_i), .fix_clk_o(fix_clk_o), .pci_clk_o(pci_clk_o),
        .mem_clk_o(mem_clk_o), .fix_oe_o(fix_oe_o), .pci_oe_o(pci_oe_o), .mem_oe_o(mem_oe_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Clock waveforms, all changed on falling edges of the core clock.
    always @(negedge clk) begin
        ph  = (ph == FIX_LEN - 1) ? 0 : ph + 1;
        mph = (mph == MEM_LEN - 1) ? 0 : mph + 1;
        fix_clk_i = (ph < FIX_LEN / 2);
        pci_src_i = {PCI_W{fix_clk_i}};
        mem_clk_i = (mph < MEM_LEN / 2);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ph(input int p);
        do begin @(negedge clk); #1; end while (ph != p);
    endtask

    task automatic wait_mph(input int p);
        do begin @(negedge clk); #1; end while (mph != p);
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk); #1;
        mode_i = m; rst = 1'b1;
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
    endtask

    // Count rising edges and high samples of pci_clk_o[0] over n core cycles.
    task automatic watch(input int n, output int rises, output int highs);
        logic prev;
        prev = pci_clk_o[0];
        rises = 0; highs = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            if (pci_clk_o[0] && !prev) rises++;
            if (pci_clk_o[0]) highs++;
            prev = pci_clk_o[0];
        end
    endtask

    initial begin
        int rises, highs;
        // R1: quiet during reset
        repeat (3) @(negedge clk);
        #1;
        check("R1 pci", 32'(pci_clk_o), 0);
        check("R1 mem", 32'(mem_clk_o), 0);
        check("R1 fix", 32'(fix_clk_o), 0);
        check("R1 oe", 32'({fix_oe_o, pci_oe_o, mem_oe_o}), 0);

        // Vector walk: R2, R3, R6, R7, R9 in steady state
        for (int v = 0; v < 8; v++) begin
            do_reset(VEC[v][5]);
            pci_stop_n_i = VEC[v][4];
            mem_stop_n_i = VEC[v][3];
            oe_i         = VEC[v][2];
            repeat (6 * FIX_LEN) @(negedge clk);
            wait_ph(2);
            check("R3/R6 pci level", 32'(pci_clk_o), VEC[v][1] ? 32'h1f : 32'h0);
            check("R2 fix level", 32'(fix_clk_o), 1);
            check("R9 enables", 32'({fix_oe_o, pci_oe_o, mem_oe_o}), VEC[v][2] ? 7 : 0);
            wait_mph(2);
            check("R7 mem level", 32'(mem_clk_o), VEC[v][0] ? 32'h1fff : 32'h0);
        end

        // R4 and R5: stop latency and whole pulses
        do_reset(1'b1);
        oe_i = 1'b1; pci_stop_n_i = 1'b1;
        repeat (4 * FIX_LEN) @(negedge clk);
        wait_ph(5);
        pci_stop_n_i = 1'b0;
        watch(6 * FIX_LEN, rises, highs);
        check("R4 pulses after stop", 32'(rises), 2);
        check("R5 high samples after stop", 32'(highs), 8);
        wait_ph(5);
        pci_stop_n_i = 1'b1;
        watch(6 * FIX_LEN, rises, highs);
        check("R4 pulses after resume", 32'(rises), 4);
        check("R5 high samples after resume", 32'(highs), 16);

        // R6: mode raised after reset is ignored
        do_reset(1'b0);
        mode_i = 1'b1; pci_stop_n_i = 1'b0;
        repeat (6 * FIX_LEN) @(negedge clk);
        wait_ph(2);
        check("R6 late mode ignored", 32'(pci_clk_o), 32'h1f);
        wait_ph(6);
        check("R2 fix low phase", 32'(fix_clk_o), 0);

        // R9: enable drop with stops active
        mem_stop_n_i = 1'b0;
        @(negedge clk); #1 oe_i = 1'b0;
        @(negedge clk); #1;
        check("R9 enable off", 32'({fix_oe_o, pci_oe_o, mem_oe_o}), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule